// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block turns a packet held in a small external byte buffer into a waveform on the two USB data lines at the low-speed bit rate. The rate is one bit every eleven clocks. On a start strobe it takes a byte count and drives the idle J state onto the lines. It then enables its drivers and sends a sync byte that it generates itself, followed by the buffer contents.

Every bit is NRZI-coded, and a stuffed transition is inserted after each run of six ones. A counted end-of-packet sequence and a release of the bus close the transfer.

The packet contents come from the surrounding logic and already include the PID and any CRC. The block reads the buffer through a registered read port, one address at a time. When the packet just sent was a data packet rather than a two-byte handshake, the block moves a pending device address into its active address register at the moment it lets go of the bus. A one-clock done pulse follows.

Top module: `lsusb_tx`

## Requirements
- R1: After reset, oe, dp, dm and done are 0 and dev_addr is 0.
- R2: A start accepted while the block is idle drives J onto the lines for one clock with oe low. J means dp=0 and dm=1. oe then rises while J is held for one more clock, and the first bit follows on the next clock.
- R3: The first eight bit slots carry the sync byte 0x80, least significant bit first. They are followed by buffer entries 0 up to count-2, each sent least significant bit first. rd_data must present the entry at rd_addr one clock after rd_addr changes.
- R4: Each bit slot lasts exactly 11 clocks. A 0 bit swaps the line between J and K (K means dp=1 and dm=0), and a 1 bit keeps the line level.
- R5: After six consecutive 1 bits, one extra swap is inserted as a stuffed bit. The run of ones is counted across byte boundaries, including the trailing 1 of the sync byte. A run that ends on the last bit of the packet is stuffed as well.
- R6: One slot after the last bit or stuffed bit, SE0 (dp=0, dm=0) is driven for exactly 22 clocks. J is then driven for one clock, after which oe falls and both lines go to 0.
- R7: done is high for exactly one clock, and that clock is the one after the clock in which oe fell.
- R8: dev_addr takes the value of new_addr at the edge where oe falls, but only when the packet had three or more bytes. After a two-byte handshake, and at every other time, dev_addr holds its value.
- R9: A start strobe is ignored from the clock after it is accepted until done is pulsed. The waveform in progress is unchanged and no second packet follows.
- R10: A byte_count below 2 is treated as 2, and a byte_count above 12 is treated as 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, eleven cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transmission (taken only when idle) |
| byte_count | input | 4 | Number of bytes including sync, 2 to 12 |
| rd_data | input | 8 | Buffer entry at rd_addr, one clock after the address |
| new_addr | input | 7 | Pending device address |
| rd_addr | output | 4 | Buffer read address |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Line driver enable |
| done | output | 1 | One-clock pulse after the bus is released |
| dev_addr | output | 7 | Active device address |

## Verification
The bench sweeps packets whose payload bytes step through the whole byte range. It also sends all-ones payloads that force stuffing inside a byte, across byte boundaries and after the final bit. Each slot is sampled on its first and last clock, so a divider that is off by one, a stuff counter that resets at byte edges, or a missing trailing stuff bit shows up as a wrong level in a named slot.

The end-of-packet sequence is checked clock by clock. A short or long SE0, a skipped J or a misplaced done pulse is reported at the cycle where it occurs. The bench also checks that handshakes leave the address alone while data packets move it, that out-of-range counts are clamped, and that a start pulsed mid-packet changes nothing.

// File: rtl/lsusb_tx_pkg.sv
`timescale 1ns/1ps
package lsusb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_BITS, ST_SE0, ST_JEND, ST_FIN
  } tx_state_e;

  // what the serializer wants on the line in the next slot
  typedef enum logic [1:0] {
    SYM_KEEP, SYM_FLIP, SYM_END
  } tx_sym_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/lsusb_tx_timer.sv
`timescale 1ns/1ps
module lsusb_tx_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] last_val,
  output logic         at_zero,
  output logic         at_last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (cnt_q == last_val)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign at_zero = (cnt_q == '0);
  assign at_last = (cnt_q == last_val);
endmodule

// File: rtl/lsusb_tx_serial.sv
`timescale 1ns/1ps
module lsusb_tx_serial
  import lsusb_tx_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int AW      = 4,
  parameter int RUN_LEN = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             step,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    rd_addr,
  output tx_sym_e          sym
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [7:0]       shift_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] left_q;
  logic [RUN_W-1:0] run_q;
  logic             more_q;
  logic [AW-1:0]    addr_q;
  logic             stuff_due;

  assign stuff_due = (run_q == RUN_W'(RUN_LEN));
  assign rd_addr   = addr_q;

  always_comb begin
    if (stuff_due)
      sym = SYM_FLIP;
    else if (more_q)
      sym = shift_q[0] ? SYM_KEEP : SYM_FLIP;
    else
      sym = SYM_END;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      run_q   <= '0;
      more_q  <= 1'b0;
      addr_q  <= '0;
    end else if (load) begin
      shift_q <= SYNC_BYTE;
      bit_q   <= '0;
      run_q   <= '0;
      more_q  <= 1'b1;
      addr_q  <= '0;
      left_q  <= nbytes - 1'b1;
    end else if (step) begin
      if (stuff_due) begin
        run_q <= '0;
      end else if (more_q) begin
        run_q   <= shift_q[0] ? run_q + 1'b1 : '0;
        shift_q <= shift_q >> 1;
        bit_q   <= bit_q + 1'b1;
        if (bit_q == 3'd7) begin
          if (left_q != '0) begin
            shift_q <= rd_data;
            addr_q  <= addr_q + 1'b1;
            left_q  <= left_q - 1'b1;
          end else begin
            more_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lsusb_tx_ctrl.sv
`timescale 1ns/1ps
module lsusb_tx_ctrl
  import lsusb_tx_pkg::*;
#(
  parameter int BIT_CLKS  = 11,
  parameter int EOP_CLKS  = 22,
  parameter int TW        = 5,
  parameter int CNT_W     = 4,
  parameter int HS_BYTES  = 2,
  parameter int ADDR_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CNT_W-1:0]     nbytes,
  input  tx_sym_e              sym,
  input  logic                 tmr_zero,
  input  logic                 tmr_last,
  input  logic [ADDR_BITS-1:0] new_addr,
  output logic                 tmr_clr,
  output logic [TW-1:0]        tmr_last_val,
  output logic                 load,
  output logic                 step,
  output logic                 dp,
  output logic                 dm,
  output logic                 oe,
  output logic                 done,
  output logic [ADDR_BITS-1:0] dev_addr
);
  tx_state_e state_q;
  logic      is_data_q;

  assign load         = (state_q == ST_IDLE) && start;
  assign step         = (state_q == ST_BITS) && tmr_zero;
  assign tmr_clr      = (state_q == ST_PREP) || (step && sym == SYM_END);
  assign tmr_last_val = (state_q == ST_SE0) ? TW'(EOP_CLKS - 1) : TW'(BIT_CLKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      is_data_q <= 1'b0;
      dp        <= 1'b0;
      dm        <= 1'b0;
      oe        <= 1'b0;
      done      <= 1'b0;
      dev_addr  <= '0;
    end else begin
      done <= (state_q == ST_FIN);
      case (state_q)
        ST_IDLE: if (start) begin
          dp        <= 1'b0;
          dm        <= 1'b1;
          is_data_q <= (nbytes > CNT_W'(HS_BYTES));
          state_q   <= ST_PREP;
        end
        ST_PREP: begin
          oe      <= 1'b1;
          state_q <= ST_BITS;
        end
        ST_BITS: if (step) begin
          case (sym)
            SYM_FLIP: begin
              dp <= ~dp;
              dm <= ~dm;
            end
            SYM_END: begin
              dp      <= 1'b0;
              dm      <= 1'b0;
              state_q <= ST_SE0;
            end
            default: ;
          endcase
        end
        ST_SE0: if (tmr_last) begin
          dm      <= 1'b1;
          state_q <= ST_JEND;
        end
        ST_JEND: begin
          oe <= 1'b0;
          dp <= 1'b0;
          dm <= 1'b0;
          if (is_data_q) dev_addr <= new_addr;
          state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsusb_tx.sv
`timescale 1ns/1ps
module lsusb_tx
  import lsusb_tx_pkg::*;
#(
  parameter int BIT_CLKS  = 11,
  parameter int EOP_CLKS  = 22,
  parameter int MIN_BYTES = 2,
  parameter int MAX_BYTES = 12,
  parameter int RUN_LEN   = 6,
  parameter int ADDR_BITS = 7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [$clog2(MAX_BYTES+1)-1:0] byte_count,
  input  logic [7:0]                     rd_data,
  input  logic [ADDR_BITS-1:0]           new_addr,
  output logic [$clog2(MAX_BYTES)-1:0]   rd_addr,
  output logic                           dp,
  output logic                           dm,
  output logic                           oe,
  output logic                           done,
  output logic [ADDR_BITS-1:0]           dev_addr
);
  localparam int CNT_W   = $clog2(MAX_BYTES + 1);
  localparam int AW      = $clog2(MAX_BYTES);
  localparam int TMR_TOP = (EOP_CLKS > BIT_CLKS) ? EOP_CLKS : BIT_CLKS;
  localparam int TW      = $clog2(TMR_TOP);

  logic [CNT_W-1:0] nbytes;
  logic             tmr_clr, tmr_zero, tmr_last, load, step;
  logic [TW-1:0]    tmr_last_val;
  tx_sym_e          sym;

  always_comb begin
    if (byte_count < CNT_W'(MIN_BYTES))
      nbytes = CNT_W'(MIN_BYTES);
    else if (byte_count > CNT_W'(MAX_BYTES))
      nbytes = CNT_W'(MAX_BYTES);
    else
      nbytes = byte_count;
  end

  lsusb_tx_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .last_val(tmr_last_val),
    .at_zero(tmr_zero), .at_last(tmr_last)
  );

  lsusb_tx_serial #(.CNT_W(CNT_W), .AW(AW), .RUN_LEN(RUN_LEN)) u_serial (
    .clk(clk), .rst(rst), .load(load), .nbytes(nbytes), .step(step),
    .rd_data(rd_data), .rd_addr(rd_addr), .sym(sym)
  );

  lsusb_tx_ctrl #(
    .BIT_CLKS(BIT_CLKS), .EOP_CLKS(EOP_CLKS), .TW(TW), .CNT_W(CNT_W),
    .HS_BYTES(MIN_BYTES), .ADDR_BITS(ADDR_BITS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .nbytes(nbytes), .sym(sym),
    .tmr_zero(tmr_zero), .tmr_last(tmr_last), .new_addr(new_addr),
    .tmr_clr(tmr_clr), .tmr_last_val(tmr_last_val), .load(load), .step(step),
    .dp(dp), .dm(dm), .oe(oe), .done(done), .dev_addr(dev_addr)
  );
endmodule

// File: rtl/lsusb_tx_chk.sv
`timescale 1ns/1ps
module lsusb_tx_chk #(
  parameter int EOP_CLKS  = 22,
  parameter int ADDR_BITS = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 dp,
  input logic                 dm,
  input logic                 oe,
  input logic                 done,
  input logic [ADDR_BITS-1:0] dev_addr
);
  logic [7:0] se0_run;

  always_ff @(posedge clk) begin
    if (rst)
      se0_run <= '0;
    else if (oe && !dp && !dm)
      se0_run <= (se0_run == 8'hFF) ? se0_run : se0_run + 1'b1;
    else
      se0_run <= '0;
  end

  AST_OE_AFTER_J: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (!dp && dm && !$past(dp) && $past(dm))); // R2

  AST_NO_BOTH_HIGH: assert property (@(posedge clk) disable iff (rst)
    !(dp && dm)); // R4

  AST_SE0_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (oe && !dp && dm && se0_run != 8'd0) |-> (se0_run == 8'(EOP_CLKS))); // R6

  AST_RELEASE_FROM_J: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> (!$past(dp) && $past(dm))); // R6

  AST_DONE_PLACE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!oe && !$past(oe) && $past(oe, 2))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_ADDR_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dev_addr) |-> $fell(oe)); // R8
endmodule

bind lsusb_tx lsusb_tx_chk #(.EOP_CLKS(EOP_CLKS), .ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rst(rst), .dp(dp), .dm(dm), .oe(oe), .done(done), .dev_addr(dev_addr)
);

// File: tb/lsusb_tx_tb.sv
`timescale 1ns/1ps
module lsusb_tx_tb;
  logic       clk = 1'b0;
  logic       rst, start;
  logic [3:0] byte_count;
  logic [7:0] rd_data;
  logic [6:0] new_addr;
  logic [3:0] rd_addr;
  logic       dp, dm, oe, done;
  logic [6:0] dev_addr;

  logic [7:0] mem [0:15];
  logic [1:0] exp_lvl [0:127];
  logic       exp_stf [0:127];
  int         nslots;
  int         total = 0;
  int         bad   = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  lsusb_tx u_dut (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .rd_data(rd_data), .new_addr(new_addr), .rd_addr(rd_addr),
    .dp(dp), .dm(dm), .oe(oe), .done(done), .dev_addr(dev_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected line level per slot: J=2'b01, K=2'b10 as {dp,dm}
  task automatic build(input int n);
    logic [1:0] lvl;
    int         ones;
    lvl = 2'b01; ones = 0; nslots = 0;
    for (int b = 0; b < n; b++) begin
      logic [7:0] v;
      v = (b == 0) ? 8'h80 : mem[b-1];
      for (int i = 0; i < 8; i++) begin
        if (!v[i]) begin lvl = ~lvl; ones = 0; end
        else ones++;
        exp_lvl[nslots] = lvl; exp_stf[nslots] = 1'b0; nslots++;
        if (ones == 6) begin
          lvl = ~lvl; ones = 0;
          exp_lvl[nslots] = lvl; exp_stf[nslots] = 1'b1; nslots++;
        end
      end
    end
  endtask

  task automatic run_pkt(input int cnt_in, input bit poke);
    int         n;
    logic [6:0] a0;
    string      tag;
    n  = (cnt_in < 2) ? 2 : (cnt_in > 12) ? 12 : cnt_in;
    a0 = dev_addr;
    build(n);
    @(negedge clk); start = 1'b1; byte_count = 4'(cnt_in);
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk(!oe && {dp,dm} == 2'b01, "R2", "J before enable", {oe,dp,dm}, 3'b001);
    @(posedge clk);
    @(negedge clk);
    chk(oe && {dp,dm} == 2'b01, "R2", "enable with J", {oe,dp,dm}, 3'b101);
    for (int j = 0; j < nslots; j++) begin
      tag = exp_stf[j] ? "R5" : (j < 8 ? "R3" : "R4");
      @(posedge clk);
      @(negedge clk);
      chk(oe && {dp,dm} == exp_lvl[j], tag, $sformatf("slot %0d first clock", j),
          {dp,dm}, exp_lvl[j]);
      if (poke && j == 3) begin start = 1'b1; byte_count = 4'd12; end
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(oe && {dp,dm} == exp_lvl[j], tag, $sformatf("slot %0d last clock", j),
          {dp,dm}, exp_lvl[j]);
      if (poke && j == 3) start = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(oe && {dp,dm} == 2'b00, "R6", "SE0 begins", {oe,dp,dm}, 3'b100);
    repeat (21) @(posedge clk);
    @(negedge clk);
    chk(oe && {dp,dm} == 2'b00, "R6", "SE0 last clock", {oe,dp,dm}, 3'b100);
    @(posedge clk);
    @(negedge clk);
    chk(oe && {dp,dm} == 2'b01, "R6", "J after SE0", {oe,dp,dm}, 3'b101);
    chk(dev_addr == a0, "R8", "address before release", dev_addr, a0);
    @(posedge clk);
    @(negedge clk);
    chk(!oe && {dp,dm} == 2'b00, "R6", "bus released", {oe,dp,dm}, 3'b000);
    chk(!done, "R7", "done not yet", done, 0);
    chk(dev_addr == ((n > 2) ? new_addr : a0), "R8", "address after release",
        dev_addr, (n > 2) ? new_addr : a0);
    @(posedge clk);
    @(negedge clk);
    chk(done, "R7", "done pulse", done, 1);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R7", "done drops", done, 0);
    if (poke) begin
      int seen;
      seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (oe) seen++;
      end
      chk(seen == 0, "R9", "no packet from busy start", seen, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    rst = 1'b1; start = 1'b0; byte_count = 4'd2; new_addr = 7'h2A;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!oe && !dp && !dm && !done && dev_addr == 0, "R1", "reset state",
        {oe,dp,dm,done,dev_addr}, 0);
    rst = 1'b0;

    // handshake: address must stay
    mem[0] = 8'hD2;
    run_pkt(2, 1'b0);
    chk(dev_addr == 7'h00, "R8", "handshake keeps address", dev_addr, 0);

    // stuffing inside bytes, across a boundary and after the final bit
    mem[0] = 8'hC3; mem[1] = 8'hFF; mem[2] = 8'hFF;
    run_pkt(4, 1'b0);

    // longest packet, start pulsed while busy
    new_addr = 7'h15;
    for (int i = 0; i < 11; i++) mem[i] = 8'hFF;
    run_pkt(12, 1'b1);

    // count below range acts as a handshake
    new_addr = 7'h33; mem[0] = 8'h5A;
    run_pkt(1, 1'b0);
    chk(dev_addr == 7'h15, "R10", "count 1 treated as 2", dev_addr, 7'h15);

    // count above range acts as 12
    for (int i = 0; i < 11; i++) mem[i] = 8'(i * 37 + 5);
    run_pkt(15, 1'b0);
    chk(dev_addr == 7'h33, "R10", "count 15 treated as 12", dev_addr, 7'h33);

    // payload sweep
    for (int v = 0; v < 256; v += 3) begin
      mem[0] = 8'(v); mem[1] = 8'(v) ^ 8'hA5;
      new_addr = 7'(v);
      run_pkt(3, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule